// File: doc/BRIEF.md
# Parallel Flash Program and Erase Sequencer

This block sits on the host side of a byte-wide parallel flash device and runs one program or erase operation from start to finish. A request arrives on a valid/ready handshake. It carries an operation code, a target address, a data byte and a completion-detection mode. The sequencer then emits the unlock write sequence with the right chip-enable, write-enable and output-enable strobing. After that it issues status reads until the device reports completion or a poll limit runs out. It closes the operation with a one-cycle done pulse and two error flags.

Two ways of detecting completion are supported. In polling mode, bit 7 of a status read is compared against the value it must take when the operation has finished. In toggle mode, the sequencer watches bit 6 and stops once two consecutive status reads return the same value. After a program operation finishes successfully, one more read checks the whole byte. All bus timing is counted in clock cycles through parameters.

Top module: `fpe_sequencer`

## Requirements
- R1: `req_ready` is high exactly when the sequencer is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_op`, `req_addr`, `req_data` and `cfg_toggle` are captured at that edge. `req_ready` stays low until the cycle in which `done` pulses.
- R2: Operation code 0 (program) produces four writes, as (address, data) pairs: (0x05555, 0xAA), (0x02AAA, 0x55), (0x05555, 0xA0), then (target address, data byte).
- R3: Operation codes 1 (sector), 2 (block) and 3 (chip) produce six writes. The first five are (0x05555, 0xAA), (0x02AAA, 0x55), (0x05555, 0x80), (0x05555, 0xAA), (0x02AAA, 0x55). The sixth write depends on the code. Sector sends 0x30 to the target address with its low 12 bits cleared. Block sends 0x50 to the target address with its low 16 bits cleared. Chip sends 0x10 to 0x05555.
- R4: During a write cycle, CE# is low, OE# is high and the data bus is driven, while WE# is low for exactly WR_LEN clocks. During a read cycle, CE# and OE# are low for exactly RD_LEN clocks with WE# high and the data bus not driven. Between cycles, all three strobes are high.
- R5: In polling mode, a program operation completes on the first status read whose bit 7 equals bit 7 of the programmed byte.
- R6: In polling mode, an erase operation completes on the first status read whose bit 7 is 1.
- R7: In toggle mode, an operation completes on the first status read whose bit 6 equals bit 6 of the status read immediately before it. The first status read of an operation never completes it.
- R8: If POLL_MAX status reads pass without completion, the operation ends with `err_timeout` = 1 and no further read.
- R9: A completion found on the POLL_MAX-th status read counts as success, not as a timeout.
- R10: Status reads and the verify read use the request's target address. After a successful program, exactly one extra read takes place, and `err_verify` is 1 if its byte differs from the data byte. Erase operations perform no extra read.
- R11: `done` is high for exactly one cycle per operation. `err_timeout` and `err_verify` are valid with `done` and hold their values until the next request is taken. After reset, all flags are 0 and all strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_op | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| req_addr | input | AW | Target address |
| req_data | input | 8 | Byte to program |
| cfg_toggle | input | 1 | 1 selects toggle-bit detection, 0 selects bit-7 polling |
| done | output | 1 | One-cycle end-of-operation pulse |
| err_timeout | output | 1 | Poll limit reached without completion |
| err_verify | output | 1 | Verify read after program mismatched |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_addr | output | AW | Flash address bus |
| fl_dq_out | output | 8 | Data driven to the flash |
| fl_dq_oe | output | 1 | Drive enable for fl_dq_out |
| fl_dq_in | input | 8 | Data returned by the flash |

## Verification
Completion detection and the poll-limit check can fall on the same status read. The bench provokes this by setting the device model's busy-read count so that the completing read is exactly the POLL_MAX-th one. It does this in both modes and for both program and erase, and expects success with a verify read for programs. The sweep over busy-read counts also covers the read just before and just after that boundary. On each side, the bench judges the outcome by the number of reads observed on the bus and by the error flags, and the expected values are computed arithmetically from the mode and the count.

// File: rtl/fpe_pkg.sv
package fpe_pkg;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SECT = 2'd1,
        OP_BLK  = 2'd2,
        OP_CHIP = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CMD,
        ST_POLL,
        ST_VERIFY
    } seq_st_e;

    typedef enum logic [1:0] {
        BE_IDLE,
        BE_ACT,
        BE_GAP
    } bus_st_e;

    // context needed to judge one status read
    typedef struct packed {
        logic toggle;
        logic erase;
        logic exp7;
        logic prev6;
        logic have_prev;
    } judge_ctx_t;

    localparam logic [7:0] CODE_UNLK1 = 8'hAA;
    localparam logic [7:0] CODE_UNLK2 = 8'h55;
    localparam logic [7:0] CODE_PROG  = 8'hA0;
    localparam logic [7:0] CODE_ERASE = 8'h80;
    localparam logic [7:0] CODE_CHIP  = 8'h10;
    localparam logic [7:0] CODE_SECT  = 8'h30;
    localparam logic [7:0] CODE_BLK   = 8'h50;

    function automatic logic op_is_erase(op_e op);
        return op != OP_PROG;
    endfunction

endpackage

// File: rtl/fpe_cmd_seq.sv
module fpe_cmd_seq
    import fpe_pkg::*;
#(
    parameter int AW = 19,
    parameter logic [AW-1:0] UNLOCK_A = 19'h05555,
    parameter logic [AW-1:0] UNLOCK_B = 19'h02AAA,
    parameter int SECT_BITS = 12,
    parameter int BLK_BITS  = 16
) (
    input  op_e           op,
    input  logic [2:0]    idx,
    input  logic [AW-1:0] tgt_addr,
    input  logic [7:0]    tgt_data,
    output logic [AW-1:0] st_addr,
    output logic [7:0]    st_data,
    output logic          st_last
);

    localparam logic [AW-1:0] SECT_MASK = {AW{1'b1}} << SECT_BITS;
    localparam logic [AW-1:0] BLK_MASK  = {AW{1'b1}} << BLK_BITS;

    always_comb begin
        st_addr = UNLOCK_A;
        st_data = CODE_UNLK1;
        st_last = 1'b0;
        if (op == OP_PROG) begin
            case (idx)
                3'd0: ;
                3'd1: begin st_addr = UNLOCK_B; st_data = CODE_UNLK2; end
                3'd2: st_data = CODE_PROG;
                default: begin
                    st_addr = tgt_addr;
                    st_data = tgt_data;
                    st_last = 1'b1;
                end
            endcase
        end else begin
            case (idx)
                3'd0, 3'd3: ;
                3'd1, 3'd4: begin st_addr = UNLOCK_B; st_data = CODE_UNLK2; end
                3'd2: st_data = CODE_ERASE;
                default: begin
                    st_last = 1'b1;
                    case (op)
                        OP_SECT: begin st_addr = tgt_addr & SECT_MASK; st_data = CODE_SECT; end
                        OP_BLK:  begin st_addr = tgt_addr & BLK_MASK;  st_data = CODE_BLK;  end
                        default: begin st_addr = UNLOCK_A;             st_data = CODE_CHIP; end
                    endcase
                end
            endcase
        end
    end

endmodule

// File: rtl/fpe_bus_engine.sv
module fpe_bus_engine
    import fpe_pkg::*;
#(
    parameter int AW     = 19,
    parameter int WR_LEN = 3,
    parameter int RD_LEN = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          is_write,
    input  logic [AW-1:0] addr_in,
    input  logic [7:0]    data_in,
    output logic          cyc_done,
    output logic [7:0]    rd_data,
    output logic          ce_n,
    output logic          we_n,
    output logic          oe_n,
    output logic [AW-1:0] bus_addr,
    output logic [7:0]    dq_out,
    output logic          dq_oe,
    input  logic [7:0]    dq_in
);

    localparam int LMAX = (WR_LEN > RD_LEN) ? WR_LEN : RD_LEN;
    localparam int CW   = $clog2(LMAX + 1);

    bus_st_e       st_q;
    logic          wr_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_lim;

    assign cnt_lim = wr_q ? CW'(WR_LEN - 1) : CW'(RD_LEN - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= BE_IDLE;
            wr_q     <= 1'b0;
            cnt_q    <= '0;
            bus_addr <= '0;
            dq_out   <= '0;
            rd_data  <= '0;
        end else begin
            case (st_q)
                BE_IDLE: if (start) begin
                    st_q     <= BE_ACT;
                    wr_q     <= is_write;
                    bus_addr <= addr_in;
                    dq_out   <= data_in;
                    cnt_q    <= '0;
                end
                BE_ACT: begin
                    if (cnt_q == cnt_lim) begin
                        if (!wr_q) rd_data <= dq_in;
                        st_q <= BE_GAP;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: st_q <= BE_IDLE;
            endcase
        end
    end

    assign cyc_done = (st_q == BE_GAP);
    assign ce_n     = !(st_q == BE_ACT);
    assign we_n     = !((st_q == BE_ACT) && wr_q);
    assign oe_n     = !((st_q == BE_ACT) && !wr_q);
    assign dq_oe    = wr_q && (st_q != BE_IDLE);

    // independent width monitor for the write strobe
    logic [CW:0] we_low_q;
    always_ff @(posedge clk) begin
        if (rst) we_low_q <= '0;
        else     we_low_q <= we_n ? '0 : we_low_q + 1'b1;
    end

    // R4: write strobe and read strobe never overlap
    a_r4_we_oe_excl: assert property (@(posedge clk) disable iff (rst)
        !(!we_n && !oe_n));
    // R4: any active strobe implies chip enable
    a_r4_ce_with_strobe: assert property (@(posedge clk) disable iff (rst)
        (!we_n || !oe_n) |-> !ce_n);
    // R4: write pulse lasts exactly WR_LEN clocks
    a_r4_we_width: assert property (@(posedge clk) disable iff (rst)
        $rose(we_n) |-> (we_low_q == (CW+1)'(WR_LEN)));
    // R4: bus never driven while the flash drives it
    a_r4_dq_direction: assert property (@(posedge clk) disable iff (rst)
        !oe_n |-> !dq_oe);

endmodule

// File: rtl/fpe_poll_judge.sv
module fpe_poll_judge
    import fpe_pkg::*;
(
    input  judge_ctx_t ctx,
    input  logic [7:0] status,
    output logic       complete
);

    always_comb begin
        if (ctx.toggle)
            complete = ctx.have_prev && (status[6] == ctx.prev6);
        else if (ctx.erase)
            complete = status[7];
        else
            complete = (status[7] == ctx.exp7);
    end

endmodule

// File: rtl/fpe_sequencer.sv
module fpe_sequencer
    import fpe_pkg::*;
#(
    parameter int AW        = 19,
    parameter int WR_LEN    = 3,
    parameter int RD_LEN    = 2,
    parameter int POLL_MAX  = 4096,
    parameter int SECT_BITS = 12,
    parameter int BLK_BITS  = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [7:0]    req_data,
    input  logic          cfg_toggle,
    output logic          done,
    output logic          err_timeout,
    output logic          err_verify,
    output logic          fl_ce_n,
    output logic          fl_we_n,
    output logic          fl_oe_n,
    output logic [AW-1:0] fl_addr,
    output logic [7:0]    fl_dq_out,
    output logic          fl_dq_oe,
    input  logic [7:0]    fl_dq_in
);

    localparam int PW = $clog2(POLL_MAX + 1);

    seq_st_e       st_q;
    op_e           op_q;
    logic [AW-1:0] addr_q;
    logic [7:0]    data_q;
    logic          tog_q;
    logic [2:0]    idx_q;
    logic          pend_q;
    logic [PW-1:0] pcnt_q;
    logic [PW-1:0] pcnt_nx;
    logic          prev6_q;
    logic          havep_q;

    logic [AW-1:0] step_addr;
    logic [7:0]    step_data;
    logic          step_last;
    logic          bus_start;
    logic          bus_done;
    logic [7:0]    bus_rd;
    logic [AW-1:0] bus_addr_in;
    judge_ctx_t    jctx;
    logic          complete;

    fpe_cmd_seq #(
        .AW(AW), .SECT_BITS(SECT_BITS), .BLK_BITS(BLK_BITS)
    ) u_cmd (
        .op(op_q), .idx(idx_q), .tgt_addr(addr_q), .tgt_data(data_q),
        .st_addr(step_addr), .st_data(step_data), .st_last(step_last)
    );

    assign bus_start   = (st_q != ST_IDLE) && !pend_q;
    assign bus_addr_in = (st_q == ST_CMD) ? step_addr : addr_q;

    fpe_bus_engine #(
        .AW(AW), .WR_LEN(WR_LEN), .RD_LEN(RD_LEN)
    ) u_bus (
        .clk(clk), .rst(rst), .start(bus_start), .is_write(st_q == ST_CMD),
        .addr_in(bus_addr_in), .data_in(step_data),
        .cyc_done(bus_done), .rd_data(bus_rd),
        .ce_n(fl_ce_n), .we_n(fl_we_n), .oe_n(fl_oe_n),
        .bus_addr(fl_addr), .dq_out(fl_dq_out), .dq_oe(fl_dq_oe),
        .dq_in(fl_dq_in)
    );

    assign jctx = '{toggle: tog_q, erase: op_is_erase(op_q), exp7: data_q[7],
                    prev6: prev6_q, have_prev: havep_q};

    fpe_poll_judge u_judge (
        .ctx(jctx), .status(bus_rd), .complete(complete)
    );

    assign req_ready = (st_q == ST_IDLE);
    assign pcnt_nx   = pcnt_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_IDLE;
            op_q        <= OP_PROG;
            addr_q      <= '0;
            data_q      <= '0;
            tog_q       <= 1'b0;
            idx_q       <= '0;
            pend_q      <= 1'b0;
            pcnt_q      <= '0;
            prev6_q     <= 1'b0;
            havep_q     <= 1'b0;
            done        <= 1'b0;
            err_timeout <= 1'b0;
            err_verify  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (st_q == ST_IDLE) begin
                if (req_valid) begin
                    op_q        <= op_e'(req_op);
                    addr_q      <= req_addr;
                    data_q      <= req_data;
                    tog_q       <= cfg_toggle;
                    idx_q       <= '0;
                    pend_q      <= 1'b0;
                    pcnt_q      <= '0;
                    havep_q     <= 1'b0;
                    err_timeout <= 1'b0;
                    err_verify  <= 1'b0;
                    st_q        <= ST_CMD;
                end
            end else begin
                if (bus_start) pend_q <= 1'b1;
                if (bus_done) begin
                    pend_q <= 1'b0;
                    case (st_q)
                        ST_CMD: begin
                            if (step_last) st_q <= ST_POLL;
                            else           idx_q <= idx_q + 1'b1;
                        end
                        ST_POLL: begin
                            if (complete) begin
                                if (op_q == OP_PROG) begin
                                    st_q <= ST_VERIFY;
                                end else begin
                                    st_q <= ST_IDLE;
                                    done <= 1'b1;
                                end
                            end else if (pcnt_nx == PW'(POLL_MAX)) begin
                                err_timeout <= 1'b1;
                                st_q        <= ST_IDLE;
                                done        <= 1'b1;
                            end else begin
                                pcnt_q  <= pcnt_nx;
                                prev6_q <= bus_rd[6];
                                havep_q <= 1'b1;
                            end
                        end
                        default: begin
                            err_verify <= (bus_rd != data_q);
                            st_q       <= ST_IDLE;
                            done       <= 1'b1;
                        end
                    endcase
                end
            end
        end
    end

    // R1: ready falls after a request is taken
    a_r1_ready_drop: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);
    // R1: done coincides with the return to idle
    a_r1_done_ready: assert property (@(posedge clk) disable iff (rst)
        done |-> req_ready);
    // R11: done is a single-cycle pulse
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R8: timeout and verify error are never both reported
    a_r8_flag_exclusive: assert property (@(posedge clk) disable iff (rst)
        done |-> !(err_timeout && err_verify));
    // R8: poll counter stays below its limit
    a_r8_poll_bound: assert property (@(posedge clk) disable iff (rst)
        pcnt_q < PW'(POLL_MAX));
    // R11: flags hold while idle with no new request
    a_r11_flags_hold: assert property (@(posedge clk) disable iff (rst)
        (req_ready && !done && !req_valid) |=> $stable(err_timeout) && $stable(err_verify));

endmodule

// File: tb/sim_fpe_sequencer.sv
module sim_fpe_sequencer;

    localparam int AW  = 19;
    localparam int WRL = 3;
    localparam int RDL = 2;
    localparam int PMX = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_data = '0;
    logic          cfg_toggle = 1'b0;
    logic          done, err_timeout, err_verify;
    logic          fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe;
    logic [AW-1:0] fl_addr;
    logic [7:0]    fl_dq_out;
    logic [7:0]    dq_model = 8'h00;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    fpe_sequencer #(.AW(AW), .WR_LEN(WRL), .RD_LEN(RDL), .POLL_MAX(PMX)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
        .cfg_toggle(cfg_toggle), .done(done), .err_timeout(err_timeout),
        .err_verify(err_verify), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n),
        .fl_oe_n(fl_oe_n), .fl_addr(fl_addr), .fl_dq_out(fl_dq_out),
        .fl_dq_oe(fl_dq_oe), .fl_dq_in(dq_model)
    );

    // device model state
    int            m_busy = 0;
    logic          m_corrupt = 1'b0;
    logic          m_prog = 1'b1;
    logic [7:0]    m_data = '0;
    int            nw = 0;
    int            nreads = 0;
    logic [AW-1:0] wa [0:7];
    logic [7:0]    wd [0:7];
    logic [AW-1:0] last_rd_addr = '0;
    logic          rd_addr_bad = 1'b0;
    int            viol = 0;
    int            rdy_viol = 0;
    logic          in_op = 1'b0;
    logic          prev_we = 1'b1, prev_oe = 1'b1;
    int            we_cnt = 0, oe_cnt = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] resp(input int n);
        logic [7:0] v;
        if (n <= m_busy) begin
            v = m_data;
            v[7] = m_prog ? ~m_data[7] : 1'b0;
            v[6] = n[0];
        end else begin
            v = m_prog ? (m_data ^ (m_corrupt ? 8'h01 : 8'h00)) : 8'hFF;
        end
        return v;
    endfunction

    always @(negedge clk) begin
        if (!rst) begin
            if (!fl_we_n && prev_we) begin
                if (nw < 8) begin wa[nw] = fl_addr; wd[nw] = fl_dq_out; end
                nw++;
                nreads = 0;
            end
            if (!fl_oe_n && prev_oe) begin
                nreads++;
                last_rd_addr = fl_addr;
                if (fl_addr != req_addr_q) rd_addr_bad = 1'b1;
                dq_model = resp(nreads);
            end
            // R4 strobe rules
            if (!fl_we_n && (fl_ce_n || !fl_oe_n || !fl_dq_oe)) viol++;
            if (!fl_oe_n && (fl_ce_n || fl_dq_oe || !fl_we_n)) viol++;
            if (fl_we_n && fl_oe_n && !fl_ce_n) viol++;
            if (!fl_we_n) we_cnt++;
            else if (!prev_we) begin if (we_cnt != WRL) viol++; we_cnt = 0; end
            if (!fl_oe_n) oe_cnt++;
            else if (!prev_oe) begin if (oe_cnt != RDL) viol++; oe_cnt = 0; end
            if (in_op && req_ready && !done) rdy_viol++;
            prev_we = fl_we_n;
            prev_oe = fl_oe_n;
        end
    end

    logic [AW-1:0] req_addr_q = '0;

    task automatic run_op(input logic [1:0] op, input logic [AW-1:0] addr,
                          input logic [7:0] data, input logic tog,
                          input int busy, input logic corrupt);
        logic [AW-1:0] ea [0:5];
        logic [7:0]    ed [0:5];
        int ne, ncomp, exp_reads, wait_n;
        bit exp_to, exp_ver, ok, got_to, got_ver;
        string mtag;
        m_busy = busy; m_corrupt = corrupt; m_prog = (op == 2'd0); m_data = data;
        nw = 0; nreads = 0; viol = 0; rdy_viol = 0; rd_addr_bad = 1'b0;
        req_addr_q = addr;
        // expected write list
        ea[0] = 19'h05555; ed[0] = 8'hAA;
        ea[1] = 19'h02AAA; ed[1] = 8'h55;
        if (op == 2'd0) begin
            ne = 4; ea[2] = 19'h05555; ed[2] = 8'hA0; ea[3] = addr; ed[3] = data;
            ea[4] = '0; ed[4] = '0; ea[5] = '0; ed[5] = '0;
        end else begin
            ne = 6; ea[2] = 19'h05555; ed[2] = 8'h80;
            ea[3] = 19'h05555; ed[3] = 8'hAA; ea[4] = 19'h02AAA; ed[4] = 8'h55;
            if (op == 2'd1)      begin ea[5] = {addr[AW-1:12], 12'h000}; ed[5] = 8'h30; end
            else if (op == 2'd2) begin ea[5] = {addr[AW-1:16], 16'h0000}; ed[5] = 8'h50; end
            else                 begin ea[5] = 19'h05555; ed[5] = 8'h10; end
        end
        // expected completion read index
        if (!tog) ncomp = busy + 1;
        else begin
            logic f;
            f = m_prog ? data[6] : 1'b1;
            ncomp = (busy >= 1 && f == logic'(busy[0])) ? busy + 1 : busy + 2;
        end
        exp_to    = ncomp > PMX;
        exp_reads = exp_to ? PMX : ncomp + (m_prog ? 1 : 0);
        exp_ver   = m_prog && !exp_to && corrupt;
        mtag = tog ? "R7" : (m_prog ? "R5" : "R6");
        // handshake
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = addr; req_data = data; cfg_toggle = tog;
        do @(posedge clk); while (!req_ready);
        @(negedge clk);
        req_valid = 1'b0; req_op = ~op; req_data = ~data; cfg_toggle = ~tog;
        in_op = 1'b1;
        wait_n = 0;
        while (!done && wait_n < 3000) begin @(negedge clk); wait_n++; end
        in_op = 1'b0;
        got_to = err_timeout; got_ver = err_verify;
        chk(done, "R11", "done seen", done, 1);
        ok = (nw == ne);
        for (int i = 0; i < 6; i++)
            if (i < ne && i < nw && (wa[i] != ea[i] || wd[i] != ed[i])) ok = 0;
        chk(ok, (op == 2'd0) ? "R2" : "R3", "write sequence", nw, ne);
        chk(nreads == exp_reads, exp_to ? "R8" : (ncomp == PMX ? "R9" : mtag),
            "status read count", nreads, exp_reads);
        chk(got_to == exp_to, (ncomp == PMX) ? "R9" : "R8", "timeout flag", got_to, exp_to);
        chk(got_ver == exp_ver, "R10", "verify flag", got_ver, exp_ver);
        chk(!rd_addr_bad, "R10", "read address", last_rd_addr, addr);
        chk(viol == 0, "R4", "strobe violations", viol, 0);
        chk(rdy_viol == 0, "R1", "ready while busy", rdy_viol, 0);
        @(negedge clk);
        chk(!done && err_timeout == got_to && err_verify == got_ver, "R11",
            "pulse width and flag hold", {done, err_timeout, err_verify}, {1'b0, got_to, got_ver});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 / R11 reset state
        chk(req_ready && !done && !err_timeout && !err_verify, "R11", "reset flags",
            {req_ready, done, err_timeout, err_verify}, 4'b1000);
        chk(fl_ce_n && fl_we_n && fl_oe_n && !fl_dq_oe, "R4", "reset strobes",
            {fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe}, 4'b1110);
        for (int op = 0; op < 4; op++)
            for (int t = 0; t < 2; t++)
                for (int b = 0; b <= PMX + 1; b++)
                    run_op(2'(op), 19'h12345 + 19'(op * 19'h11111 + b * 19'h0235),
                           8'(op * 37 + b * 91 + t * 64 + 5), logic'(t), b, 1'b0);
        // R10 verify mismatch and boundary cases
        run_op(2'd0, 19'h0ABCD, 8'hC3, 1'b0, 2, 1'b1);
        run_op(2'd0, 19'h0ABCD, 8'h3C, 1'b1, 3, 1'b1);
        run_op(2'd0, 19'h7FFFF, 8'h80, 1'b0, PMX - 1, 1'b1);
        run_op(2'd0, 19'h7FFFF, 8'h80, 1'b0, PMX, 1'b1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule